// File: doc/BRIEF.md
# Holdover Frequency History Keeper

This block sits beside a timing loop and remembers what frequency the loop was running at. While the loop is locked and tracking, each frequency-control word that the loop reports is folded into a smoothed history value. Once enough samples have been folded in, the history is flagged as usable. When the loop is told to hold over, the block supplies the frequency word that the oscillator should keep. It uses the history if the history is usable. If it is not, it keeps the last word the loop produced. It also counts how many seconds have passed since holdover began.

A second storage slot keeps a spare copy of the history. A two-bit command input can copy the live history into the spare slot, copy the spare slot back into the live history, or wipe the live history. Each copy carries its usable flag with it. Commands work in any state. Holdover may be requested at any moment, whatever state the history is in.

Top module: `holdover_hist`

## Requirements
- R1: After reset, `freq_out`, `hist_word`, `bkup_word` and `hold_secs` are zero, and `hist_ok` and `bkup_ok` are low.
- R2: A sample is accepted on a clock edge where `smp_valid` is high, `hold_req` is low and `cmd_op` is 2'b00. If the fill count is zero, the accepted sample is copied straight into `hist_word`. Otherwise `hist_word` becomes `hist + ((sample - hist) >>> SHIFT)`. The difference is signed and one bit wider than the word, the shift is arithmetic, and the sum is truncated to the word width.
- R3: `hist_ok` goes high once FILL samples have been accepted since reset or since the last wipe. The fill count saturates at FILL.
- R4: `cmd_op` = 2'b01 (save) copies `hist_word` into `bkup_word` and `hist_ok` into `bkup_ok` on that edge.
- R5: `cmd_op` = 2'b10 (recall) copies `bkup_word` into `hist_word`. The fill count is set to FILL when `bkup_ok` is high and to zero when it is low, so `hist_ok` follows `bkup_ok`.
- R6: `cmd_op` = 2'b11 (wipe) sets `hist_word` to zero, sets the fill count to zero, and drops `hist_ok`.
- R7: When a command is present, a sample presented on the same edge is discarded. Neither the history nor the last loop word changes because of it.
- R8: While `hold_req` is low, `freq_out` equals the last accepted sample word. It changes on the edge after the sample.
- R9: While `hold_req` is high, `freq_out` equals `hist_word` when `hist_ok` is high. When `hist_ok` is low, it equals the last sample accepted before entry. Samples do not change anything during holdover.
- R10: On the first edge where `hold_req` is high, `hold_secs` clears to zero. On each later edge in holdover with `sec_tick` high, it counts up and saturates at 2^TW-1. After holdover ends it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req | input | 1 | Holdover requested |
| smp_valid | input | 1 | Frequency sample strobe from the loop |
| smp_word | input | FW | Frequency-control word from the loop |
| sec_tick | input | 1 | One-second time-base pulse |
| cmd_op | input | 2 | 00 none, 01 save, 10 recall, 11 wipe |
| freq_out | output | FW | Frequency word for the oscillator |
| hist_word | output | FW | Live history value |
| hist_ok | output | 1 | Live history is usable |
| bkup_word | output | FW | Spare history copy |
| bkup_ok | output | 1 | Spare copy is usable |
| hold_secs | output | TW | Seconds elapsed in holdover |

## Verification
The bench uses FW=16, SHIFT=4 and FILL=16, which match the default averaging behaviour on a narrower word. It sets TW=4, so the seconds counter saturates at 15. A holdover of about twenty ticks then reaches saturation, which a wide counter would never do in a short run. A 16-bit word keeps the random sample values spread across the full range, so large signed differences in both directions reach the averaging arithmetic.

// File: rtl/holdover_hist.sv
module holdover_hist #(
  parameter int FW    = 24,
  parameter int SHIFT = 4,
  parameter int FILL  = 16,
  parameter int TW    = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_req,
  input  logic          smp_valid,
  input  logic [FW-1:0] smp_word,
  input  logic          sec_tick,
  input  logic [1:0]    cmd_op,
  output logic [FW-1:0] freq_out,
  output logic [FW-1:0] hist_word,
  output logic          hist_ok,
  output logic [FW-1:0] bkup_word,
  output logic          bkup_ok,
  output logic [TW-1:0] hold_secs
);
  localparam int CW = $clog2(FILL + 1);
  localparam logic [CW-1:0] FULL = CW'(FILL);
  localparam logic [TW-1:0] TMAX = {TW{1'b1}};
  localparam logic [1:0] OP_SAVE = 2'b01, OP_RECALL = 2'b10, OP_WIPE = 2'b11;

  logic [FW-1:0] hist_q, bkup_q, last_q;
  logic [CW-1:0] fill_q;
  logic          bkup_ok_q, hold_q;
  logic [TW-1:0] secs_q;

  wire has_cmd = cmd_op != 2'b00;
  wire accept  = smp_valid && !hold_req && !has_cmd;
  wire entry   = hold_req && !hold_q;

  logic signed [FW:0] diff, step;
  logic [FW-1:0]      ema;
  assign diff = $signed({1'b0, smp_word}) - $signed({1'b0, hist_q});
  assign step = diff >>> SHIFT;
  assign ema  = hist_q + step[FW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q    <= '0;
      fill_q    <= '0;
      bkup_q    <= '0;
      bkup_ok_q <= 1'b0;
      last_q    <= '0;
    end else begin
      case (cmd_op)
        OP_SAVE: begin
          bkup_q    <= hist_q;
          bkup_ok_q <= fill_q == FULL;
        end
        OP_RECALL: begin
          hist_q <= bkup_q;
          fill_q <= bkup_ok_q ? FULL : '0;
        end
        OP_WIPE: begin
          hist_q <= '0;
          fill_q <= '0;
        end
        default: if (accept) begin
          hist_q <= (fill_q == '0) ? smp_word : ema;
          if (fill_q != FULL) fill_q <= fill_q + 1'b1;
          last_q <= smp_word;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      secs_q <= '0;
    end else begin
      hold_q <= hold_req;
      if (entry)                                   secs_q <= '0;
      else if (hold_req && sec_tick && secs_q != TMAX) secs_q <= secs_q + 1'b1;
    end
  end

  assign hist_word = hist_q;
  assign hist_ok   = fill_q == FULL;
  assign bkup_word = bkup_q;
  assign bkup_ok   = bkup_ok_q;
  assign hold_secs = secs_q;
  assign freq_out  = (hold_req && hist_ok) ? hist_q : last_q;

  // R10
  secs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_req) |=> hold_secs == '0);
  // R10
  secs_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_req && $past(hold_req) && hold_secs == TMAX |=> hold_secs == TMAX);
  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_req && cmd_op == 2'b00 |=> $stable(hist_word) && $stable(hist_ok));
  // R4
  save_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == OP_SAVE |=> bkup_word == $past(hist_word) && bkup_ok == $past(hist_ok));
  // R6
  wipe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == OP_WIPE |=> !hist_ok && hist_word == '0);
  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_req && !hist_ok && $past(hold_req) && $past(!hist_ok) |-> $stable(freq_out));
endmodule

// File: tb/tb_holdover_hist.sv
module tb_holdover_hist;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 16, SHIFT = 4, FILL = 16, TW = 4;
  localparam logic [TW-1:0] TMAX = {TW{1'b1}};

  logic clk = 0, rst_n = 0;
  logic hold_req = 0, smp_valid = 0, sec_tick = 0;
  logic [FW-1:0] smp_word = '0;
  logic [1:0] cmd_op = 2'b00;
  logic [FW-1:0] freq_out, hist_word, bkup_word;
  logic hist_ok, bkup_ok;
  logic [TW-1:0] hold_secs;

  holdover_hist #(.FW(FW), .SHIFT(SHIFT), .FILL(FILL), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .smp_valid(smp_valid),
    .smp_word(smp_word), .sec_tick(sec_tick), .cmd_op(cmd_op),
    .freq_out(freq_out), .hist_word(hist_word), .hist_ok(hist_ok),
    .bkup_word(bkup_word), .bkup_ok(bkup_ok), .hold_secs(hold_secs));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [FW-1:0] m_hist = 0, m_bk = 0, m_last = 0;
  int m_cnt = 0;
  logic m_bko = 0, m_hold = 0;
  logic [TW-1:0] m_secs = 0;

  function automatic logic [FW-1:0] avg(input logic [FW-1:0] h, input logic [FW-1:0] s);
    logic signed [FW:0] d;
    d = $signed({1'b0, s}) - $signed({1'b0, h});
    d = d >>> SHIFT;
    return h + d[FW-1:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (cmd_op == 2'b01) begin m_bk = m_hist; m_bko = (m_cnt == FILL); end
    else if (cmd_op == 2'b10) begin m_hist = m_bk; m_cnt = m_bko ? FILL : 0; end
    else if (cmd_op == 2'b11) begin m_hist = '0; m_cnt = 0; end
    else if (smp_valid && !hold_req) begin
      m_hist = (m_cnt == 0) ? smp_word : avg(m_hist, smp_word);
      if (m_cnt < FILL) m_cnt++;
      m_last = smp_word;
    end
    if (hold_req && !m_hold) m_secs = '0;
    else if (hold_req && sec_tick && m_secs != TMAX) m_secs = m_secs + 1'b1;
    m_hold = hold_req;
  endtask

  task automatic check_all();
    logic ok;
    ok = (m_cnt == FILL);
    chk("R2 hist_word", hist_word, m_hist);
    chk("R3 hist_ok", hist_ok, ok);
    chk("R4 bkup_word", bkup_word, m_bk);
    chk("R4 bkup_ok", bkup_ok, m_bko);
    chk("R10 hold_secs", hold_secs, m_secs);
    if (hold_req) chk("R9 freq_out", freq_out, ok ? m_hist : m_last);
    else          chk("R8 freq_out", freq_out, m_last);
  endtask

  task automatic step(input logic h, input logic v, input logic [FW-1:0] w,
                      input logic t, input logic [1:0] op);
    @(negedge clk);
    hold_req = h; smp_valid = v; smp_word = w; sec_tick = t; cmd_op = op;
    @(posedge clk);
    model_edge();
    #1;
    check_all();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #(CLK_PERIOD * 3);
    // R1 reset values
    chk("R1 freq_out", freq_out, 0);
    chk("R1 hist_word", hist_word, 0);
    chk("R1 hist_ok", hist_ok, 0);
    chk("R1 bkup", {bkup_ok, bkup_word}, 0);
    chk("R1 hold_secs", hold_secs, 0);
    @(negedge clk); rst_n = 1;

    // R2 seed then average; R3 fill boundary
    step(0, 1, 16'h1000, 0, 2'b00);
    chk("R2 seed", hist_word, 16'h1000);
    step(0, 1, 16'h0000, 0, 2'b00);
    chk("R2 negative step", hist_word, 16'h0F00);
    for (int i = 0; i < 13; i++) step(0, 1, 16'h2000, 0, 2'b00);
    chk("R3 not yet full", hist_ok, 0);
    step(0, 1, 16'h2000, 0, 2'b00);
    chk("R3 full after FILL", hist_ok, 1);

    // R7 command beats sample
    step(0, 1, 16'hFFFF, 0, 2'b01);
    chk("R7 last word kept", freq_out, 16'h2000);
    chk("R4 save ok", bkup_ok, 1);

    // R6 wipe
    step(0, 0, 0, 0, 2'b11);
    chk("R6 wiped word", hist_word, 0);
    chk("R6 wiped ok", hist_ok, 0);

    // R9 holdover with no usable history keeps last word, samples ignored
    step(1, 1, 16'h5555, 1, 2'b00);
    chk("R9 fallback", freq_out, 16'h2000);
    chk("R10 cleared on entry", hold_secs, 0);
    // R5 recall inside holdover
    step(1, 0, 0, 0, 2'b10);
    chk("R5 recall ok", hist_ok, 1);
    chk("R9 from history", freq_out, m_bk);
    for (int i = 0; i < 20; i++) step(1, 1, 16'h7777, 1, 2'b00);
    chk("R10 saturated", hold_secs, TMAX);
    step(0, 0, 0, 1, 2'b00);
    chk("R10 retained", hold_secs, TMAX);

    for (int i = 0; i < 4000; i++) begin
      logic h;
      logic [1:0] op;
      h = ($urandom % 20 == 0) ? ~hold_req : hold_req;
      op = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      step(h, ($urandom % 10) < 7, 16'($urandom), $urandom % 2 == 0, op);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule